// File: doc/BRIEF.md
# TDM Audio Serial Transmitter

This block sends audio samples out as a time-division-multiplexed serial stream. Software, or a DMA engine, writes a 32-bit word into a single-entry holding buffer. At the start of each enabled slot the block takes that word. It rotates the word right in nibble steps and ANDs it with a mask. It then shifts the slot's bits out on the serial data pin, MSB or LSB first. The block makes its own bit clock from the system clock through two divider stages. It also makes its own frame sync, which can be one bit wide or one slot wide, with either polarity. The first data bit of a frame can trail the frame-sync edge by zero, one or two bit clocks.

The block starts up in stages. There are separate run controls for the high-rate divider, the bit-clock divider, the serializer, the state machine and the frame-sync generator, and the intended order of release is the order given here. A ready level and a one-cycle request strobe show when the buffer is empty. If no word is waiting when an enabled slot begins, the block sends zeros in that slot and pulses an underrun flag.

Top module: `tdm_tx`

## Requirements
- R1: The slot length is (slot_code+1)*2 bit clocks for the legal odd codes 3 to 15 (8 to 32 bits). One frame lasts slot_count*slot length bit clocks, so two frame-sync starts are that far apart.
- R2: The word sent in a slot is the buffered word rotated right by 4*rot_sel bits, then ANDed with data_mask. A bit cleared by the mask goes out as 0.
- R3: With msb_first=1 a slot sends bit (slot length-1) of the transformed word first and bit 0 last. With msb_first=0 it sends bit 0 first and bit (slot length-1) last.
- R4: A frame holds slot_count slots (2 to 32), numbered from 0. Slot n carries data only when slot_en[n] is 1. A disabled slot drives sdata to 0 and takes no word from the buffer.
- R5: When fs_slot_wide=0 the frame sync is active for the first bit of slot 0 only. When fs_slot_wide=1 it is active for all of slot 0. The active level is 1 when fs_invert=0 and 0 when fs_invert=1, and the other level is the inactive one.
- R6: The first data bit of slot 0 is launched data_delay bit clocks (0, 1 or 2) after the first frame-sync bit. sdata is 0 before that.
- R7: While bclk_run is 0, bclk holds its idle level (1 when bclk_invert=0). While fs_run or sm_run is 0, fsync stays inactive and sdata stays 0. Framing begins at slot 0, bit 0, on the first launch after both are 1.
- R8: ready is 1 when ser_run and sm_run are 1 and the buffer is empty. A write (wr_en while ser_run is 1) fills the buffer, and ready is 0 on the next cycle. req pulses for one clock each time ready rises.
- R9: With bclk_invert=0, data and frame sync change only on falling edges of bclk. With bclk_invert=1 they change only on rising edges. They stay stable at the opposite edge, where a receiver samples.
- R10: If the buffer is empty when an enabled slot starts, that slot sends all zeros and underrun pulses for one clock.
- R11: After reset with all run controls at 0, ready, req, underrun and sdata are 0, fsync is inactive and bclk is at its idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hclk_run | input | 1 | Releases the high-rate divider |
| bclk_run | input | 1 | Releases the bit-clock divider |
| ser_run | input | 1 | Releases the serializer and its buffer |
| sm_run | input | 1 | Releases the transmit state machine |
| fs_run | input | 1 | Releases the frame-sync generator |
| slot_code | input | 4 | Slot length code; length (code+1)*2 bits |
| rot_sel | input | 3 | Right rotation in 4-bit steps |
| data_mask | input | 32 | AND mask applied after rotation |
| msb_first | input | 1 | 1: MSB first, 0: LSB first |
| slot_count | input | 9 | Slots per frame, 2 to 32 |
| slot_en | input | 32 | Per-slot enable, bit n for slot n |
| fs_slot_wide | input | 1 | 0: one-bit sync, 1: one-slot sync |
| fs_invert | input | 1 | Inverts the frame sync |
| data_delay | input | 2 | Bit clocks from sync to first data bit |
| bclk_invert | input | 1 | Selects the launch edge of bclk |
| wr_en | input | 1 | Buffer write strobe |
| wr_data | input | 32 | Buffer write word |
| bclk | output | 1 | Bit clock |
| fsync | output | 1 | Frame sync |
| sdata | output | 1 | Serial data |
| ready | output | 1 | Buffer empty and block running |
| req | output | 1 | One-cycle pulse when ready rises |
| underrun | output | 1 | One-cycle pulse when an enabled slot starts with no word |

## Verification
Some properties are checked on every cycle by the assertions. These are: the bit clock resting at its idle level while its divider is held, and every launch moving bclk to the launch level. They also cover the frame sync staying inactive while framing is held, and the slot counter staying below the slot count. On the data side, they check that ready drops after a write, that req never lasts two cycles, that disabled or idle slots drive 0, and that an underrun slot starts with 0. Other behaviour only shows up over whole frames, so the directed scenarios check it. This covers the rotated, masked bit sequence in both bit orders, the three data delays, the frame length implied by the slot code, and the sync width and polarity. It also covers which words get used when some slots are disabled.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;
  localparam int WORD_W    = 32;
  localparam int MAX_SLOTS = 32;
  localparam int IDX_W     = $clog2(WORD_W);
  localparam int SLOT_W    = $clog2(MAX_SLOTS);
  localparam int CNT_W     = IDX_W + 1;

  typedef struct packed {
    logic              valid;
    logic [IDX_W-1:0]  bidx;
    logic [SLOT_W-1:0] slot;
  } tdm_pos_t;

  // slot length in bits from the 4-bit code; codes below 3 act as 8 bits
  function automatic logic [CNT_W-1:0] slot_bits(input logic [3:0] code);
    logic [CNT_W-1:0] c;
    c = (code < 4'd3) ? CNT_W'(3) : CNT_W'({code[3:1], 1'b1});
    return (c + CNT_W'(1)) << 1;
  endfunction

  // slots per frame clamped to 2..MAX_SLOTS
  function automatic logic [CNT_W-1:0] eff_slots(input logic [8:0] f);
    if (f < 9'd2)                 return CNT_W'(2);
    else if (f > 9'(MAX_SLOTS))   return CNT_W'(MAX_SLOTS);
    else                          return f[CNT_W-1:0];
  endfunction

  // rotate right by 4*rot, then mask
  function automatic logic [WORD_W-1:0] rot_mask(input logic [WORD_W-1:0] w,
                                                 input logic [2:0] rot,
                                                 input logic [WORD_W-1:0] m);
    logic [2*WORD_W-1:0] d;
    d = {w, w} >> {rot, 2'b00};
    return d[WORD_W-1:0] & m;
  endfunction

  // bit of the slot word launched at position bidx
  function automatic logic pick_bit(input logic [WORD_W-1:0] w,
                                    input logic [IDX_W-1:0] bidx,
                                    input logic [CNT_W-1:0] len,
                                    input logic msb);
    logic [CNT_W-1:0] i;
    i = msb ? (len - CNT_W'(1) - {1'b0, bidx}) : {1'b0, bidx};
    return w[i[IDX_W-1:0]];
  endfunction
endpackage

// File: rtl/tdm_tx_clkgen.sv
module tdm_tx_clkgen #(
  parameter int HCLK_DIV  = 2,
  parameter int BCLK_HALF = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hclk_run,
  input  logic bclk_run,
  input  logic bclk_inv,
  output logic bclk,
  output logic launch
);
  localparam int HW = (HCLK_DIV  > 1) ? $clog2(HCLK_DIV)  : 1;
  localparam int BW = (BCLK_HALF > 1) ? $clog2(BCLK_HALF) : 1;

  logic [HW-1:0] hcnt;
  logic [BW-1:0] bcnt;
  logic htick, toggle, raw;

  assign htick  = hclk_run && (hcnt == HW'(HCLK_DIV - 1));
  assign toggle = bclk_run && htick && (bcnt == BW'(BCLK_HALF - 1));
  assign launch = toggle && raw;
  assign bclk   = raw ^ bclk_inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      bcnt <= '0;
      raw  <= 1'b1;
    end else begin
      if (!hclk_run || htick) hcnt <= '0;
      else                    hcnt <= hcnt + HW'(1);
      if (!bclk_run)          bcnt <= '0;
      else if (toggle)        bcnt <= '0;
      else if (htick)         bcnt <= bcnt + BW'(1);
      if (!bclk_run)          raw <= 1'b1;
      else if (toggle)        raw <= ~raw;
    end
  end

  // R7
  bclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bclk_run |=> (bclk == ~bclk_inv));
  // R9
  launch_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (bclk == bclk_inv));
endmodule

// File: rtl/tdm_tx_framer.sv
module tdm_tx_framer
  import tdm_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             run,
  input  logic [CNT_W-1:0] slot_len,
  input  logic [CNT_W-1:0] n_slots,
  input  logic             fs_wide,
  input  logic             fs_inv,
  input  logic [1:0]       delay,
  output logic             fsync,
  output tdm_pos_t         dpos
);
  logic [IDX_W-1:0]  fbit;
  logic [SLOT_W-1:0] fslot;
  tdm_pos_t          cur, p1, p2;
  logic              last_bit, last_slot, fs_on;

  assign last_bit  = ({1'b0, fbit}  == slot_len - CNT_W'(1));
  assign last_slot = ({1'b0, fslot} == n_slots  - CNT_W'(1));
  assign fs_on     = (fslot == '0) && (fs_wide || fbit == '0);
  assign cur       = '{valid: run, bidx: fbit, slot: fslot};

  // data timeline trails the sync timeline by 0, 1 or 2 bits
  always_comb begin
    case (delay)
      2'd0:    dpos = cur;
      2'd1:    dpos = p1;
      default: dpos = p2;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fbit  <= '0;
      fslot <= '0;
      p1    <= '0;
      p2    <= '0;
      fsync <= 1'b0;
    end else if (!run) begin
      fbit  <= '0;
      fslot <= '0;
      p1    <= '0;
      p2    <= '0;
      fsync <= fs_inv;
    end else if (launch) begin
      fsync <= fs_on ^ fs_inv;
      p1    <= cur;
      p2    <= p1;
      if (last_bit) begin
        fbit  <= '0;
        fslot <= last_slot ? '0 : fslot + SLOT_W'(1);
      end else begin
        fbit  <= fbit + IDX_W'(1);
      end
    end
  end

  // R4
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> ({1'b0, fslot} < n_slots));
  // R7
  fs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (fsync == $past(fs_inv)));
endmodule

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer
  import tdm_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              ser_run,
  input  logic              sm_run,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  tdm_pos_t          dpos,
  input  logic [MAX_SLOTS-1:0] slot_en,
  input  logic [CNT_W-1:0]  slot_len,
  input  logic [2:0]        rot,
  input  logic [WORD_W-1:0] mask,
  input  logic              msb_first,
  output logic              sdata,
  output logic              ready,
  output logic              req,
  output logic              underrun
);
  logic              full, ready_d;
  logic [WORD_W-1:0] hold, cur_w, fresh;
  logic              slot_live, slot_head, load;

  assign slot_live = dpos.valid && slot_en[dpos.slot];
  assign slot_head = slot_live && (dpos.bidx == '0);
  assign fresh     = rot_mask(hold, rot, mask);
  assign load      = launch && slot_head && full && ser_run;
  assign ready     = ser_run && sm_run && !full;
  assign req       = ready && !ready_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full     <= 1'b0;
      ready_d  <= 1'b0;
      hold     <= '0;
      cur_w    <= '0;
      sdata    <= 1'b0;
      underrun <= 1'b0;
    end else begin
      ready_d  <= ready;
      underrun <= 1'b0;
      if (!ser_run) begin
        full  <= 1'b0;
        cur_w <= '0;
        sdata <= 1'b0;
      end else begin
        if (wr_en) begin
          hold <= wr_data;
          full <= 1'b1;
        end else if (load) begin
          full <= 1'b0;
        end
        if (launch) begin
          if (!slot_live) begin
            sdata <= 1'b0;
          end else if (slot_head) begin
            if (full) begin
              cur_w <= fresh;
              sdata <= pick_bit(fresh, '0, slot_len, msb_first);
            end else begin
              cur_w    <= '0;
              sdata    <= 1'b0;
              underrun <= 1'b1;
            end
          end else begin
            sdata <= pick_bit(cur_w, dpos.bidx, slot_len, msb_first);
          end
        end
      end
    end
  end

  // R8
  wr_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ser_run && sm_run) |=> !ready);
  // R8
  req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);
  // R10
  underrun_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> !sdata);
  // R4
  idle_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (launch && !slot_live) |=> !sdata);
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
  import tdm_tx_pkg::*;
#(
  parameter int HCLK_DIV  = 2,
  parameter int BCLK_HALF = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hclk_run,
  input  logic        bclk_run,
  input  logic        ser_run,
  input  logic        sm_run,
  input  logic        fs_run,
  input  logic [3:0]  slot_code,
  input  logic [2:0]  rot_sel,
  input  logic [31:0] data_mask,
  input  logic        msb_first,
  input  logic [8:0]  slot_count,
  input  logic [31:0] slot_en,
  input  logic        fs_slot_wide,
  input  logic        fs_invert,
  input  logic [1:0]  data_delay,
  input  logic        bclk_invert,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic        bclk,
  output logic        fsync,
  output logic        sdata,
  output logic        ready,
  output logic        req,
  output logic        underrun
);
  logic             launch, frame_run;
  logic [CNT_W-1:0] slot_len, n_slots;
  tdm_pos_t         dpos;

  assign frame_run = sm_run && fs_run;
  assign slot_len  = slot_bits(slot_code);
  assign n_slots   = eff_slots(slot_count);

  tdm_tx_clkgen #(.HCLK_DIV(HCLK_DIV), .BCLK_HALF(BCLK_HALF)) u_clk (
    .clk(clk), .rst_n(rst_n), .hclk_run(hclk_run), .bclk_run(bclk_run),
    .bclk_inv(bclk_invert), .bclk(bclk), .launch(launch));

  tdm_tx_framer u_frm (
    .clk(clk), .rst_n(rst_n), .launch(launch), .run(frame_run),
    .slot_len(slot_len), .n_slots(n_slots), .fs_wide(fs_slot_wide),
    .fs_inv(fs_invert), .delay(data_delay), .fsync(fsync), .dpos(dpos));

  tdm_tx_serializer u_ser (
    .clk(clk), .rst_n(rst_n), .launch(launch), .ser_run(ser_run),
    .sm_run(sm_run), .wr_en(wr_en), .wr_data(wr_data), .dpos(dpos),
    .slot_en(slot_en), .slot_len(slot_len), .rot(rot_sel), .mask(data_mask),
    .msb_first(msb_first), .sdata(sdata), .ready(ready), .req(req),
    .underrun(underrun));
endmodule

// File: tb/test_tdm_tx.sv
module test_tdm_tx;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, hclk_run, bclk_run, ser_run, sm_run, fs_run;
  logic [3:0] slot_code; logic [2:0] rot_sel; logic [31:0] data_mask;
  logic msb_first; logic [8:0] slot_count; logic [31:0] slot_en;
  logic fs_slot_wide, fs_invert; logic [1:0] data_delay; logic bclk_invert;
  logic wr_en; logic [31:0] wr_data;
  logic bclk, fsync, sdata, ready, req, underrun;

  tdm_tx i_tdm_tx (.*);

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic fs_s [0:511];
  logic sd_s [0:511];
  int n_words;

  task automatic check(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] word_at(input int i);
    return (32'h9E37_79B9 * (i + 1)) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic int slen();
    return (int'(slot_code) + 1) * 2;
  endfunction

  function automatic logic exp_fs(input int k);
    int f, pos;
    f = slen() * int'(slot_count);
    pos = k % f;
    return fs_slot_wide ? (pos < slen()) : (pos == 0);
  endfunction

  function automatic logic exp_data(input int k);
    int l, f, kd, posd, sl, b, nact, idx;
    logic [31:0] w, t;
    l = slen(); f = l * int'(slot_count);
    kd = k - int'(data_delay);
    if (kd < 0) return 1'b0;
    posd = kd % f; sl = posd / l; b = posd % l;
    if (!slot_en[sl]) return 1'b0;
    nact = 0; idx = 0;
    for (int j = 0; j < int'(slot_count); j++) begin
      if (slot_en[j]) begin
        nact++;
        if (j < sl) idx++;
      end
    end
    idx += (kd / f) * nact;
    if (idx >= n_words) return 1'b0;
    w = word_at(idx);
    for (int j = 0; j < 32; j++) t[j] = w[(j + 4 * int'(rot_sel)) % 32];
    t = t & data_mask;
    return msb_first ? t[l - 1 - b] : t[b];
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; hclk_run = 0; bclk_run = 0; ser_run = 0; sm_run = 0; fs_run = 0;
    wr_en = 0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic [3:0] c, input logic [2:0] r, input logic [31:0] m,
                         input logic msb, input int ns, input logic [31:0] en,
                         input logic wide, input logic finv, input logic [1:0] d,
                         input logic binv);
    slot_code = c; rot_sel = r; data_mask = m; msb_first = msb;
    slot_count = 9'(ns); slot_en = en; fs_slot_wide = wide; fs_invert = finv;
    data_delay = d; bclk_invert = binv;
  endtask

  // R11
  task automatic t_reset_state();
    set_cfg(4'd15, 3'd0, '1, 1'b1, 2, 32'h3, 1'b0, 1'b0, 2'd0, 1'b0);
    do_reset();
    repeat (3) @(negedge clk);
    check(ready == 0, "R11", "ready", ready, 0);
    check(req == 0, "R11", "req", req, 0);
    check(underrun == 0, "R11", "underrun", underrun, 0);
    check(sdata == 0, "R11", "sdata", sdata, 0);
    check(fsync == 0 && bclk == 1, "R11", "fsync/bclk", {fsync, bclk}, 2'b01);
  endtask

  // R8 handshake
  task automatic t_handshake();
    int reqs;
    do_reset();
    hclk_run = 1; bclk_run = 1; ser_run = 1;
    @(negedge clk);
    check(ready == 0, "R8", "ready with state machine held", ready, 0);
    sm_run = 1; #1;
    check(ready == 1 && req == 1, "R8", "ready/req on release", {ready, req}, 2'b11);
    @(negedge clk);
    check(req == 0, "R8", "req width", req, 0);
    wr_en = 1; wr_data = 32'h1234_5678;
    @(negedge clk);
    wr_en = 0;
    check(ready == 0, "R8", "ready after write", ready, 0);
    reqs = 0;
    repeat (20) begin @(negedge clk); if (req) reqs++; end
    check(reqs == 0, "R8", "req while full and framing held", reqs, 0);
  endtask

  // R7 staged release
  task automatic t_staged();
    int chg, bad;
    logic b0;
    set_cfg(4'd3, 3'd0, '1, 1'b1, 2, 32'h3, 1'b1, 1'b0, 2'd0, 1'b0);
    do_reset();
    hclk_run = 1;
    chg = 0; b0 = bclk;
    repeat (20) begin @(negedge clk); if (bclk != b0) chg++; end
    check(chg == 0 && b0 == 1, "R7", "bclk moves with divider held", chg, 0);
    bclk_run = 1; ser_run = 1; sm_run = 1;
    @(negedge clk); wr_en = 1; wr_data = 32'hFFFF_FFFF;
    @(negedge clk); wr_en = 0;
    bad = 0;
    repeat (60) begin @(negedge clk); if (fsync != 0 || sdata != 0) bad++; end
    check(bad == 0, "R7", "activity with frame sync held", bad, 0);
  endtask

  task automatic run_case(input string nm, input int nw, input int nsamp, input bit expect_ur);
    int ns, s0, wp, urs, bad, first_k, f, nxt, guard, edge_bad;
    logic pb, pfs, psd, samp, launch_e, exp_v, act_v;
    n_words = nw;
    do_reset();
    hclk_run = 1; repeat (2) @(negedge clk);
    bclk_run = 1; repeat (2) @(negedge clk);
    ser_run = 1;  repeat (2) @(negedge clk);
    sm_run = 1;   repeat (2) @(negedge clk);
    wr_en = 1; wr_data = word_at(0);
    @(negedge clk); wr_en = 0;
    wp = 1; fs_run = 1;
    ns = 0; urs = 0; edge_bad = 0; guard = 0;
    pb = bclk; pfs = fsync; psd = sdata;
    while (ns < nsamp && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (req && wp < nw) begin wr_en = 1; wr_data = word_at(wp); wp++; end
      else wr_en = 0;
      if (underrun) urs++;
      samp     = bclk_invert ? (pb && !bclk) : (!pb && bclk);
      launch_e = (pb != bclk) && !samp;
      if (samp) begin
        if (sdata != psd || fsync != pfs) edge_bad++;
        fs_s[ns] = fsync; sd_s[ns] = sdata; ns++;
      end
      if (!launch_e && pb == bclk && (sdata != psd || fsync != pfs)) edge_bad++;
      pb = bclk; pfs = fsync; psd = sdata;
    end
    wr_en = 0;
    check(edge_bad == 0, "R9", {nm, " change off launch edge"}, edge_bad, 0);
    s0 = -1;
    for (int i = 0; i < ns; i++) if (s0 < 0 && (fs_s[i] ^ fs_invert)) s0 = i;
    bad = 0;
    for (int i = 0; i < ((s0 < 0) ? ns : s0); i++) if (sd_s[i]) bad++;
    check(s0 >= 0 && bad == 0, "R7", {nm, " silence before first frame"}, bad, 0);
    if (s0 < 0) s0 = 0;
    f = slen() * int'(slot_count);
    nxt = -1;
    for (int i = s0 + 1; i < ns; i++)
      if (nxt < 0 && (fs_s[i] ^ fs_invert) && !(fs_s[i-1] ^ fs_invert)) nxt = i;
    check(nxt - s0 == f, "R1", {nm, " frame length"}, nxt - s0, f);
    bad = 0; first_k = -1;
    for (int k = 0; k < ns - s0; k++)
      if ((fs_s[s0 + k] ^ fs_invert) != exp_fs(k)) begin bad++; if (first_k < 0) first_k = k; end
    check(bad == 0, "R5", {nm, " frame sync pattern, first bad bit"}, first_k, -1);
    bad = 0; first_k = -1; exp_v = 0; act_v = 0;
    for (int k = 0; k < ns - s0; k++)
      if (sd_s[s0 + k] != exp_data(k)) begin
        bad++;
        if (first_k < 0) begin first_k = k; act_v = sd_s[s0 + k]; exp_v = exp_data(k); end
      end
    // R2 R3 R4 R6 data stream
    check(bad == 0, "R2/R3/R4/R6", {nm, " data bit at first mismatch"}, act_v, exp_v);
    if (expect_ur) check(urs >= 1, "R10", {nm, " underrun pulses"}, urs, 1);
    else           check(urs == 0, "R10", {nm, " no underrun when fed"}, urs, 0);
  endtask

  initial begin
    rst_n = 0; hclk_run = 0; bclk_run = 0; ser_run = 0; sm_run = 0; fs_run = 0;
    wr_en = 0; wr_data = '0;
    set_cfg(4'd15, 3'd0, '1, 1'b1, 2, 32'h3, 1'b0, 1'b0, 2'd0, 1'b0);
    t_reset_state();
    t_handshake();
    t_staged();
    // 32-bit MSB first, bit-wide sync, no delay
    set_cfg(4'd15, 3'd0, 32'hFFFF_FFFF, 1'b1, 2, 32'h3, 1'b0, 1'b0, 2'd0, 1'b0);
    run_case("w32", 64, 200, 0);
    // 16-bit LSB first, slot 2 disabled, slot-wide inverted sync, delay 1
    set_cfg(4'd7, 3'd4, 32'h0000_FFFF, 1'b0, 4, 32'hB, 1'b1, 1'b1, 2'd1, 1'b0);
    run_case("w16", 64, 200, 0);
    // 8-bit with pad bits, delay 2, launch on rising bclk
    set_cfg(4'd3, 3'd6, 32'h0000_00F3, 1'b1, 3, 32'h7, 1'b0, 1'b0, 2'd2, 1'b1);
    run_case("w8", 64, 200, 0);
    // R10: only one word supplied
    set_cfg(4'd3, 3'd6, 32'h0000_00FF, 1'b1, 2, 32'h3, 1'b1, 1'b0, 2'd0, 1'b0);
    run_case("starve", 1, 80, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule